// File: doc/BRIEF.md
# Fixed-Point Format Converter

This block takes one fixed-point sample per clock and re-expresses it in another fixed-point format. Both formats are fixed at elaboration: the total width, the number of fractional bits and whether the number is two's complement or unsigned. Conversion works on numeric value, not raw bits. The fractional point of the input is first moved to the output position. Fractional bits below the output resolution are then dropped, either by truncating or by rounding. Last, the result is fitted into the output width, either by wrapping or by clamping.

Each sample carries a valid bit, and that bit moves through the same pipeline as the data. A sample presented with its valid bit low is still converted and still flows to the output, with the valid bit low. A configurable number of extra register stages can be added at the output to meet a latency budget. The overflow indication leaves the block in the same cycle as the sample it belongs to, and it is only asserted together with the output valid bit.

Top module: `fxcv_convert`

## Requirements
- R1: The output value equals the input value whenever the input value is exactly representable in the output format. An unsigned input is zero-extended and a signed input is sign-extended before alignment.
- R2: In truncate mode, the result is the largest output-grid value that is not greater than the input (floor toward minus infinity).
- R3: In round mode, the result is the nearest output-grid value. A value exactly halfway between two grid points goes to the one with the larger magnitude, for both positive and negative inputs.
- R4: A rounding increment may carry into the integer part. For example, 2047/1024 becomes exactly 2.0 when rounded to 9 fractional bits, but 1023/512 when truncated.
- R5: The range check is made on the value after rounding. A sample that is in range when truncated can therefore overflow when rounded.
- R6: In saturate mode, a result above the largest representable value becomes that largest value. A result below the smallest representable value becomes that smallest value, which is zero for an unsigned output.
- R7: In wrap mode, and in flag mode, data_out holds the low OUT_W bits of the two's complement result. All more significant bits are discarded.
- R8: overflow is 1 exactly when the rounded result lies outside the output range. This holds in wrap, saturate and flag mode alike.
- R9: A sample taken at a clock edge appears on data_out, with valid_out high, 2+EXTRA_LAT edges later. A one-cycle valid pulse gives a one-cycle valid_out pulse, and back-to-back samples leave the block back to back.
- R10: A sample presented with valid_in low is still converted and reaches data_out after the same latency. At that point valid_out is 0 and overflow is 0.
- R11: While rst_n is low, data_out, valid_out and overflow are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | IN_W | Input sample in the input fixed-point format |
| valid_in | input | 1 | Input sample qualifier |
| data_out | output | OUT_W | Converted sample in the output format |
| valid_out | output | 1 | valid_in delayed by the pipeline latency |
| overflow | output | 1 | The sample on data_out was out of range, qualified by valid_out |

## Verification
The same sample stream is fed in parallel to seven instances that differ in rounding mode, overflow mode, output width and signedness. Each sample therefore separates truncation from rounding and wrap from clamp in the same cycle.

The stream contains exact halfway values of both signs, which separate ties-away-from-zero from plain round-half-up. It contains values just below an integer or the range top, which expose a rounding carry and overflow caused by rounding. It also contains large values of both signs, which separate wrapped, clamped and flagged outputs. An unsigned-input instance fed all-ones separates zero-extension from sign-extension. Single, back-to-back and invalid samples pin down the latency and show that the valid bit stays aligned with its data.

// File: rtl/fxcv_pkg.sv
package fxcv_pkg;
  typedef enum logic {
    QNT_TRUNC,
    QNT_ROUND
  } qnt_mode_e;

  typedef enum logic [1:0] {
    OVF_WRAP,
    OVF_SAT,
    OVF_FLAG
  } ovf_mode_e;
endpackage

// File: rtl/fxcv_delay.sv
module fxcv_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign q = d;
    end else begin : g_shift
      logic [W-1:0] sr [DEPTH];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
        end else begin
          sr[0] <= d;
          for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
        end
      end
      assign q = sr[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/fxcv_align.sv
module fxcv_align
  import fxcv_pkg::*;
#(
  parameter int        IN_W      = 16,
  parameter int        IN_FRAC   = 10,
  parameter bit        IN_SIGNED = 1'b1,
  parameter int        OUT_FRAC  = 9,
  parameter qnt_mode_e QMODE     = QNT_ROUND,
  parameter int        RW        = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IN_W-1:0]      din,
  output logic signed [RW-1:0] rounded
);
  localparam int SH   = OUT_FRAC - IN_FRAC;
  localparam int LSH  = (SH > 0) ? SH : 0;
  localparam int DROP = (SH < 0) ? -SH : 0;

  // Widen the raw input to a signed working value of the same numeric worth.
  function automatic logic signed [RW-1:0] widen(input logic [IN_W-1:0] x);
    logic signed [RW-1:0] r;
    if (IN_SIGNED) r = RW'($signed(x));
    else           r = RW'(x);
    return r;
  endfunction

  logic signed [RW-1:0] aligned_w;
  logic signed [RW-1:0] trn_w;
  logic signed [RW-1:0] rnd_w;

  // Move the input point onto the output grid (exact when LSH > 0).
  assign aligned_w = widen(din) <<< LSH;
  // Drop the bits below the output LSB: floor.
  assign trn_w     = aligned_w >>> DROP;

  generate
    if (DROP == 0) begin : g_exact
      assign rnd_w = aligned_w;
    end else begin : g_round
      // Half an output LSB, one less for negative values, gives ties away from zero.
      function automatic logic signed [RW-1:0] round_drop(input logic signed [RW-1:0] v);
        logic signed [RW-1:0] b;
        b = '0;
        b[DROP-1] = 1'b1;
        if (v[RW-1]) b = b - {{(RW-1){1'b0}}, 1'b1};
        return (v + b) >>> DROP;
      endfunction
      assign rnd_w = round_drop(aligned_w);
    end
  endgenerate

  assign rounded = (QMODE == QNT_ROUND) ? rnd_w : trn_w;

  // The rounded value is the floor or one grid step above it.
  AST_ROUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_w == trn_w) || (rnd_w == trn_w + {{(RW-1){1'b0}}, 1'b1})); // R3
endmodule

// File: rtl/fxcv_limit.sv
module fxcv_limit
  import fxcv_pkg::*;
#(
  parameter int        RW         = 18,
  parameter int        OUT_W      = 12,
  parameter bit        OUT_SIGNED = 1'b1,
  parameter ovf_mode_e OVMODE     = OVF_SAT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [RW-1:0] val,
  output logic [OUT_W-1:0]     dout,
  output logic                 ovf
);
  localparam int CW = (RW > OUT_W + 2) ? RW : OUT_W + 2;
  localparam logic signed [CW-1:0] MAXC = OUT_SIGNED ?
    {{(CW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}} :
    {{(CW-OUT_W){1'b0}}, {OUT_W{1'b1}}};
  localparam logic signed [CW-1:0] MINC = OUT_SIGNED ?
    {{(CW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}} :
    {CW{1'b0}};

  // Numeric worth of an output word, widened for comparison.
  function automatic logic signed [CW-1:0] out_value(input logic [OUT_W-1:0] w);
    logic signed [CW-1:0] r;
    if (OUT_SIGNED) r = CW'($signed(w));
    else            r = CW'(w);
    return r;
  endfunction

  logic signed [CW-1:0] vx;
  logic                 too_hi;
  logic                 too_lo;

  assign vx     = CW'(val);
  assign too_hi = vx > MAXC;
  assign too_lo = vx < MINC;
  assign ovf    = too_hi | too_lo;

  always_comb begin
    dout = vx[OUT_W-1:0];
    if (OVMODE == OVF_SAT) begin
      if (too_hi)      dout = MAXC[OUT_W-1:0];
      else if (too_lo) dout = MINC[OUT_W-1:0];
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |-> (out_value(dout) == vx)); // R1
  AST_SAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((OVMODE == OVF_SAT) && ovf) |->
      ((dout == MAXC[OUT_W-1:0]) || (dout == MINC[OUT_W-1:0]))); // R6
  AST_WRAP_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    (OVMODE != OVF_SAT) |-> (ovf == (out_value(dout) != vx))); // R8
endmodule

// File: rtl/fxcv_convert.sv
module fxcv_convert
  import fxcv_pkg::*;
#(
  parameter int        IN_W       = 16,
  parameter int        IN_FRAC    = 10,
  parameter bit        IN_SIGNED  = 1'b1,
  parameter int        OUT_W      = 12,
  parameter int        OUT_FRAC   = 9,
  parameter bit        OUT_SIGNED = 1'b1,
  parameter qnt_mode_e QMODE      = QNT_ROUND,
  parameter ovf_mode_e OVMODE     = OVF_SAT,
  parameter int        EXTRA_LAT  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  data_in,
  input  logic             valid_in,
  output logic [OUT_W-1:0] data_out,
  output logic             valid_out,
  output logic             overflow
);
  localparam int SH  = OUT_FRAC - IN_FRAC;
  localparam int LSH = (SH > 0) ? SH : 0;
  localparam int RW  = IN_W + LSH + 2;
  localparam int PW  = OUT_W + 2;

  // Stage 1: capture every sample, valid or not.
  logic [IN_W-1:0] din_q;
  logic            vin_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      din_q <= '0;
      vin_q <= 1'b0;
    end else begin
      din_q <= data_in;
      vin_q <= valid_in;
    end
  end

  logic signed [RW-1:0] rounded_w;
  logic [OUT_W-1:0]     fitted_w;
  logic                 ovf_w;

  fxcv_align #(
    .IN_W(IN_W), .IN_FRAC(IN_FRAC), .IN_SIGNED(IN_SIGNED),
    .OUT_FRAC(OUT_FRAC), .QMODE(QMODE), .RW(RW)
  ) u_align (
    .clk(clk), .rst_n(rst_n), .din(din_q), .rounded(rounded_w)
  );

  fxcv_limit #(
    .RW(RW), .OUT_W(OUT_W), .OUT_SIGNED(OUT_SIGNED), .OVMODE(OVMODE)
  ) u_limit (
    .clk(clk), .rst_n(rst_n), .val(rounded_w), .dout(fitted_w), .ovf(ovf_w)
  );

  // Stage 2: result register.
  logic [PW-1:0] res_q;
  always_ff @(posedge clk) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= {vin_q, ovf_w, fitted_w};
  end

  // Extra latency: data, flag and valid share one shift register.
  logic [PW-1:0] res_d;
  fxcv_delay #(.W(PW), .DEPTH(EXTRA_LAT)) u_delay (
    .clk(clk), .rst_n(rst_n), .d(res_q), .q(res_d)
  );

  assign data_out  = res_d[OUT_W-1:0];
  assign valid_out = res_d[PW-1];
  assign overflow  = res_d[PW-2] & res_d[PW-1];

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rst_n) |-> (!valid_out && !overflow && (data_out == '0))); // R11
endmodule

// File: tb/fxcv_convert_test.sv
`timescale 1ns/100ps
module fxcv_convert_test;
  import fxcv_pkg::*;

  localparam int EXTRA = 2;
  localparam int LAT   = 2 + EXTRA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] din = '0;
  logic        vin = 1'b0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  logic [11:0] d_a, d_b, d_g;
  logic [6:0]  d_c, d_d, d_e;
  logic [7:0]  d_f;
  logic v_a, v_b, v_c, v_d, v_e, v_f, v_g;
  logic o_a, o_b, o_c, o_d, o_e, o_f, o_g;

  fxcv_convert #(.IN_W(16), .IN_FRAC(10), .IN_SIGNED(1), .OUT_W(12), .OUT_FRAC(9),
    .OUT_SIGNED(1), .QMODE(QNT_ROUND), .OVMODE(OVF_SAT), .EXTRA_LAT(EXTRA))
    uut (.clk(clk), .rst_n(rst_n), .data_in(din), .valid_in(vin),
         .data_out(d_a), .valid_out(v_a), .overflow(o_a));
  fxcv_convert #(.IN_W(16), .IN_FRAC(10), .IN_SIGNED(1), .OUT_W(12), .OUT_FRAC(9),
    .OUT_SIGNED(1), .QMODE(QNT_TRUNC), .OVMODE(OVF_WRAP), .EXTRA_LAT(EXTRA))
    u_trwr (.clk(clk), .rst_n(rst_n), .data_in(din), .valid_in(vin),
            .data_out(d_b), .valid_out(v_b), .overflow(o_b));
  fxcv_convert #(.IN_W(16), .IN_FRAC(10), .IN_SIGNED(1), .OUT_W(7), .OUT_FRAC(4),
    .OUT_SIGNED(1), .QMODE(QNT_TRUNC), .OVMODE(OVF_WRAP), .EXTRA_LAT(EXTRA))
    u_wrap7 (.clk(clk), .rst_n(rst_n), .data_in(din), .valid_in(vin),
             .data_out(d_c), .valid_out(v_c), .overflow(o_c));
  fxcv_convert #(.IN_W(16), .IN_FRAC(10), .IN_SIGNED(1), .OUT_W(7), .OUT_FRAC(4),
    .OUT_SIGNED(1), .QMODE(QNT_ROUND), .OVMODE(OVF_SAT), .EXTRA_LAT(EXTRA))
    u_sat7 (.clk(clk), .rst_n(rst_n), .data_in(din), .valid_in(vin),
            .data_out(d_d), .valid_out(v_d), .overflow(o_d));
  fxcv_convert #(.IN_W(16), .IN_FRAC(10), .IN_SIGNED(1), .OUT_W(7), .OUT_FRAC(4),
    .OUT_SIGNED(1), .QMODE(QNT_TRUNC), .OVMODE(OVF_FLAG), .EXTRA_LAT(EXTRA))
    u_flag7 (.clk(clk), .rst_n(rst_n), .data_in(din), .valid_in(vin),
             .data_out(d_e), .valid_out(v_e), .overflow(o_e));
  fxcv_convert #(.IN_W(16), .IN_FRAC(10), .IN_SIGNED(1), .OUT_W(8), .OUT_FRAC(4),
    .OUT_SIGNED(0), .QMODE(QNT_ROUND), .OVMODE(OVF_SAT), .EXTRA_LAT(EXTRA))
    u_usat8 (.clk(clk), .rst_n(rst_n), .data_in(din), .valid_in(vin),
             .data_out(d_f), .valid_out(v_f), .overflow(o_f));
  fxcv_convert #(.IN_W(8), .IN_FRAC(2), .IN_SIGNED(0), .OUT_W(12), .OUT_FRAC(5),
    .OUT_SIGNED(1), .QMODE(QNT_TRUNC), .OVMODE(OVF_WRAP), .EXTRA_LAT(EXTRA))
    u_uin (.clk(clk), .rst_n(rst_n), .data_in(din[7:0]), .valid_in(vin),
           .data_out(d_g), .valid_out(v_g), .overflow(o_g));

  // Reference: value v counts input LSBs at ifr fractional bits.
  task automatic chk(input string req, input string nm, input logic [15:0] got,
                     input logic gv, input logic go, input longint v, input int ifr,
                     input int ow, input int of, input bit osg, input bit rnd,
                     input int ovm, input bit ev);
    real    s;
    longint q, lo, hi, mask;
    bit     ov;
    logic [15:0] eb;
    s = real'(v) * (2.0 ** (of - ifr));
    if (rnd) q = (s >= 0.0) ? longint'($floor(s + 0.5)) : -longint'($floor(-s + 0.5));
    else     q = longint'($floor(s));
    lo   = osg ? -(64'sd1 <<< (ow - 1)) : 64'sd0;
    hi   = osg ? (64'sd1 <<< (ow - 1)) - 1 : (64'sd1 <<< ow) - 1;
    mask = (64'sd1 <<< ow) - 1;
    ov   = (q > hi) || (q < lo);
    if (ovm == 1 && ov) q = (q > hi) ? hi : lo;
    eb = 16'(q & mask);
    n_chk++;
    if (got !== eb || gv !== ev || go !== (ov && ev)) begin
      n_fail++;
      $display("FAIL %s %s: data=%h valid=%b ovf=%b, expected data=%h valid=%b ovf=%b",
               req, nm, got, gv, go, eb, ev, ov && ev);
    end
  endtask

  task automatic check_set(input string req, input logic [15:0] raw, input bit ev);
    longint sv, uv;
    sv = longint'($signed(raw));
    uv = longint'(raw[7:0]);
    chk(req, "uut",     16'(d_a), v_a, o_a, sv, 10, 12, 9, 1, 1, 1, ev);
    chk(req, "u_trwr",  16'(d_b), v_b, o_b, sv, 10, 12, 9, 1, 0, 0, ev);
    chk(req, "u_wrap7", 16'(d_c), v_c, o_c, sv, 10, 7, 4, 1, 0, 0, ev);
    chk(req, "u_sat7",  16'(d_d), v_d, o_d, sv, 10, 7, 4, 1, 1, 1, ev);
    chk(req, "u_flag7", 16'(d_e), v_e, o_e, sv, 10, 7, 4, 1, 0, 2, ev);
    chk(req, "u_usat8", 16'(d_f), v_f, o_f, sv, 10, 8, 4, 0, 1, 1, ev);
    chk(req, "u_uin",   16'(d_g), v_g, o_g, uv, 2, 12, 5, 1, 0, 0, ev);
  endtask

  // Drive one sample, wait to its output cycle, check every instance.
  task automatic run_sample(input string req, input logic [15:0] raw, input bit v);
    @(negedge clk);
    din = raw;
    vin = v;
    @(negedge clk);
    vin = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    check_set(req, raw, v);
  endtask

  task automatic test_reset();
    @(negedge clk);
    n_chk++;
    if (d_a !== '0 || v_a !== 1'b0 || o_a !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 reset: data=%h valid=%b ovf=%b, expected 0 0 0", d_a, v_a, o_a);
    end
  endtask

  task automatic test_exact();           // R1
    run_sample("R1", 16'h0600, 1'b1);
    run_sample("R1", 16'h00FF, 1'b1);
  endtask

  task automatic test_quant();           // R2 R3
    run_sample("R2_R3", 16'd1781, 1'b1);
    run_sample("R2_R3", -16'sd1781, 1'b1);
    run_sample("R2_R3", 16'd1779, 1'b1);
    run_sample("R2_R3", -16'sd1779, 1'b1);
    run_sample("R2_R3", 16'd100, 1'b1);
    run_sample("R2_R3", -16'sd100, 1'b1);
    run_sample("R2_R3", -16'sd96, 1'b1);
    run_sample("R2_R3", -16'sd80, 1'b1);
  endtask

  task automatic test_carry();           // R4 R5
    run_sample("R4", 16'd2047, 1'b1);
    run_sample("R5", 16'd4095, 1'b1);
  endtask

  task automatic test_range();           // R6 R7 R8
    run_sample("R6_R7_R8", 16'd14016, 1'b1);
    run_sample("R6_R7_R8", -16'sd14016, 1'b1);
    run_sample("R6_R7_R8", 16'd20480, 1'b1);
    run_sample("R6_R8", -16'sd1536, 1'b1);
  endtask

  task automatic test_invalid();         // R10
    run_sample("R10", 16'd14016, 1'b0);
  endtask

  task automatic test_latency();         // R9
    @(negedge clk);
    din = 16'd1781;
    vin = 1'b1;
    @(negedge clk);
    din = -16'sd1781;
    @(negedge clk);
    vin = 1'b0;
    n_chk++;
    if (v_a !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 early: valid=%b, expected 0", v_a);
    end
    repeat (LAT - 2) @(negedge clk);
    chk("R9", "uut", 16'(d_a), v_a, o_a, 1781, 10, 12, 9, 1, 1, 1, 1'b1);
    @(negedge clk);
    chk("R9", "uut", 16'(d_a), v_a, o_a, -1781, 10, 12, 9, 1, 1, 1, 1'b1);
    @(negedge clk);
    n_chk++;
    if (v_a !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 tail: valid=%b, expected 0", v_a);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    test_reset();
    @(negedge clk);
    rst_n = 1'b1;
    test_exact();
    test_quant();
    test_carry();
    test_range();
    test_invalid();
    test_latency();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule